// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits between a processor that announces each bus cycle as a 3-bit status code and the system bus. It tracks the moment the code leaves the passive value and turns the code into bus strobes. These strobes are an address latch enable pulse, a transceiver enable and direction pair, and separate read and write commands for memory and for IO. It also gives an early write command for each space and an interrupt acknowledge strobe. All outputs are active high and come straight from registered state, so they are clean for one full clock each.

A small state machine has three states. `PH_IDLE` waits for a start. `PH_ADDR` is the single address-latch clock. `PH_XFER` holds the commands. There are four transitions. `IDLE->ADDR` happens when the previous sampled code was passive, the current code is not, and the strap inputs select uniprocessor operation. `ADDR->XFER` happens when the code is still non-passive. `ADDR->IDLE` and `XFER->IDLE` happen when the passive code is sampled. `XFER->XFER` holds while the code stays non-passive. The cycle type is captured in the clock that leaves `PH_IDLE` and is held until the cycle ends.

Top module: `bus_cmd_decoder`

## Requirements
- R1: While reset is asserted and in the first clock after it, every output is low.
- R2: When the sampled status moves from 111 to any other code, `ale_o` is high for exactly one clock, in the clock after that sample.
- R3: Commands assert in the clock after `ale_o` and follow the code captured at the start. 001 gives `io_rd_o`, 010 gives `io_wr_o`, 100 and 101 give `mem_rd_o`, 110 gives `mem_wr_o`, and 000 gives `int_ack_o`. Code 011 gives no command.
- R4: `mem_wr_early_o` and `io_wr_early_o` assert together with `ale_o`, one clock before the matching normal write. They stay high until the cycle ends.
- R5: `xcvr_en_o` asserts in the clock after `ale_o` for every code except 011, and stays high until the cycle ends.
- R6: `xcvr_tx_o` is 1 (transmit) from the `ale_o` clock to the end of a write cycle (010 or 110). It is 0 (receive) at all other times.
- R7: A sample of status 111 clears every command, `xcvr_en_o` and `xcvr_tx_o` in the next clock.
- R8: Changes of status between non-passive codes during a cycle are ignored. The captured code stays in force, and no new `ale_o` occurs until status has returned to 111.
- R9: A cycle starts only when `arb_grant_n_i`=0, `io_dedicated_i`=0 and `strobe_en_i`=1. Otherwise a status change leaves every output low.
- R10: At most one of the five command outputs other than the early writes is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_stat_i | input | 3 | Bus cycle status code, 111 = passive |
| arb_grant_n_i | input | 1 | Arbitration grant strap, low for uniprocessor |
| io_dedicated_i | input | 1 | Dedicated IO bus strap, low for uniprocessor |
| strobe_en_i | input | 1 | Command enable strap, high for uniprocessor |
| ale_o | output | 1 | Address latch enable pulse |
| xcvr_en_o | output | 1 | Data transceiver enable |
| xcvr_tx_o | output | 1 | Transceiver direction, 1 = transmit |
| mem_rd_o | output | 1 | Memory read command |
| mem_wr_o | output | 1 | Memory write command |
| mem_wr_early_o | output | 1 | Early memory write command |
| io_rd_o | output | 1 | IO read command |
| io_wr_o | output | 1 | IO write command |
| io_wr_early_o | output | 1 | Early IO write command |
| int_ack_o | output | 1 | Interrupt acknowledge command |

## Verification
The hardest case is a cycle whose status jumps straight to another non-passive code while the cycle is still running. A naive decoder would follow the new code or emit a second address pulse. The driver holds one code for the address clock and then drives a different non-passive code through the transfer clocks. It expects the original command and no second `ale_o`. It also runs cycles that return to passive straight after the address clock, so no transfer clock occurs, and it repeats status changes with each strap held out of uniprocessor mode.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int STAT_W = 3;

    typedef enum logic [STAT_W-1:0] {
        ST_INTA    = 3'b000,
        ST_IORD    = 3'b001,
        ST_IOWR    = 3'b010,
        ST_HALT    = 3'b011,
        ST_CODE    = 3'b100,
        ST_MRD     = 3'b101,
        ST_MWR     = 3'b110,
        ST_PASSIVE = 3'b111
    } bus_stat_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_XFER = 2'd2
    } phase_e;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
        logic inta;
        logic is_write;
        logic has_data;
    } cyc_kind_t;
endpackage

// File: rtl/bcd_status_decode.sv
module bcd_status_decode
    import bcd_pkg::*;
(
    input  logic [STAT_W-1:0] stat,
    output cyc_kind_t         kind
);
    always_comb begin
        kind = '0;
        unique case (bus_stat_e'(stat))
            ST_INTA: begin
                kind.inta     = 1'b1;
                kind.has_data = 1'b1;
            end
            ST_IORD: begin
                kind.io_rd    = 1'b1;
                kind.has_data = 1'b1;
            end
            ST_IOWR: begin
                kind.io_wr    = 1'b1;
                kind.is_write = 1'b1;
                kind.has_data = 1'b1;
            end
            ST_CODE, ST_MRD: begin
                kind.mem_rd   = 1'b1;
                kind.has_data = 1'b1;
            end
            ST_MWR: begin
                kind.mem_wr   = 1'b1;
                kind.is_write = 1'b1;
                kind.has_data = 1'b1;
            end
            ST_HALT, ST_PASSIVE: kind = '0;
            default: kind = '0;
        endcase
    end
endmodule

// File: rtl/bcd_cycle_fsm.sv
module bcd_cycle_fsm
    import bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat,
    input  logic              uni_mode,
    output phase_e            phase,
    output logic              start
);
    logic [STAT_W-1:0] stat_q;
    phase_e            phase_d;
    logic              now_passive;

    assign now_passive = (stat == ST_PASSIVE);
    assign start = (phase == PH_IDLE) && uni_mode &&
                   (stat_q == ST_PASSIVE) && !now_passive;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            stat_q <= ST_PASSIVE;
        end else begin
            phase  <= phase_d;
            stat_q <= stat;
        end
    end

    always_comb begin
        phase_d = phase;
        unique case (phase)
            PH_IDLE: if (start) phase_d = PH_ADDR;
            PH_ADDR: phase_d = now_passive ? PH_IDLE : PH_XFER;
            PH_XFER: if (now_passive) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // R2: address phase lasts a single clock
    p_addr_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ADDR) |=> (phase != PH_ADDR));

    // R9: outside uniprocessor mode an idle machine stays idle
    p_gate_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!uni_mode && phase == PH_IDLE) |=> (phase == PH_IDLE));

    // R8: no re-entry to the address phase from a running cycle
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_XFER) |=> (phase != PH_ADDR));
endmodule

// File: rtl/bcd_cmd_gen.sv
module bcd_cmd_gen
    import bcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  phase_e    phase,
    input  logic      start,
    input  cyc_kind_t kind_in,
    output logic      ale_o,
    output logic      xcvr_en_o,
    output logic      xcvr_tx_o,
    output logic      mem_rd_o,
    output logic      mem_wr_o,
    output logic      mem_wr_early_o,
    output logic      io_rd_o,
    output logic      io_wr_o,
    output logic      io_wr_early_o,
    output logic      int_ack_o
);
    cyc_kind_t kind_q;
    logic      in_cycle;
    logic      in_xfer;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     kind_q <= '0;
        else if (start) kind_q <= kind_in;
    end

    assign in_cycle = (phase != PH_IDLE);
    assign in_xfer  = (phase == PH_XFER);

    always_comb begin
        ale_o          = (phase == PH_ADDR);
        xcvr_en_o      = in_xfer  && kind_q.has_data;
        xcvr_tx_o      = in_cycle && kind_q.is_write;
        mem_rd_o       = in_xfer  && kind_q.mem_rd;
        mem_wr_o       = in_xfer  && kind_q.mem_wr;
        mem_wr_early_o = in_cycle && kind_q.mem_wr;
        io_rd_o        = in_xfer  && kind_q.io_rd;
        io_wr_o        = in_xfer  && kind_q.io_wr;
        io_wr_early_o  = in_cycle && kind_q.io_wr;
        int_ack_o      = in_xfer  && kind_q.inta;
    end

    // R4: a normal write is always preceded by its early write
    p_mem_early_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_o) |-> $past(mem_wr_early_o));
    p_io_early_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_wr_o) |-> $past(io_wr_early_o));

    // R5: transceiver enable only rises right after the latch pulse
    p_den_after_ale_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xcvr_en_o) |-> $past(ale_o));

    // R10: one command at a time
    p_cmd_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, int_ack_o}));
endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
    import bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] bus_stat_i,
    input  logic              arb_grant_n_i,
    input  logic              io_dedicated_i,
    input  logic              strobe_en_i,
    output logic              ale_o,
    output logic              xcvr_en_o,
    output logic              xcvr_tx_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              mem_wr_early_o,
    output logic              io_rd_o,
    output logic              io_wr_o,
    output logic              io_wr_early_o,
    output logic              int_ack_o
);
    phase_e    phase;
    logic      start;
    logic      uni_mode;
    cyc_kind_t kind;

    assign uni_mode = !arb_grant_n_i && !io_dedicated_i && strobe_en_i;

    bcd_status_decode u_dec (
        .stat (bus_stat_i),
        .kind (kind)
    );

    bcd_cycle_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat     (bus_stat_i),
        .uni_mode (uni_mode),
        .phase    (phase),
        .start    (start)
    );

    bcd_cmd_gen u_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .phase          (phase),
        .start          (start),
        .kind_in        (kind),
        .ale_o          (ale_o),
        .xcvr_en_o      (xcvr_en_o),
        .xcvr_tx_o      (xcvr_tx_o),
        .mem_rd_o       (mem_rd_o),
        .mem_wr_o       (mem_wr_o),
        .mem_wr_early_o (mem_wr_early_o),
        .io_rd_o        (io_rd_o),
        .io_wr_o        (io_wr_o),
        .io_wr_early_o  (io_wr_early_o),
        .int_ack_o      (int_ack_o)
    );

    // R7: a passive sample ends every command in the next clock
    p_passive_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stat_i == ST_PASSIVE) |=>
            !(xcvr_en_o || xcvr_tx_o || mem_rd_o || mem_wr_o || mem_wr_early_o ||
              io_rd_o || io_wr_o || io_wr_early_o || int_ack_o));
endmodule

// File: tb/bus_cmd_decoder_tb_top.sv
module bus_cmd_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] stat = 3'b111;
    logic       agn = 1'b0, iod = 1'b0, sen = 1'b1;
    logic ale, den, dt, mrd, mwr, mwx, iord, iowr, iowx, inta;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct { logic [9:0] v; string tag; } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    bus_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .bus_stat_i(stat),
        .arb_grant_n_i(agn), .io_dedicated_i(iod), .strobe_en_i(sen),
        .ale_o(ale), .xcvr_en_o(den), .xcvr_tx_o(dt),
        .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_wr_early_o(mwx),
        .io_rd_o(iord), .io_wr_o(iowr), .io_wr_early_o(iowx), .int_ack_o(inta)
    );

    function automatic logic [9:0] outs();
        return {ale, den, dt, mrd, mwr, mwx, iord, iowr, iowx, inta};
    endfunction

    // expected vector {ale,den,dt,mrd,mwr,mwx,iord,iowr,iowx,inta}; ph 0 = address clock, 1 = transfer clock
    function automatic logic [9:0] exp_vec(input logic [2:0] c, input bit ph);
        logic wr;
        wr = (c == 3'b010) || (c == 3'b110);
        return {!ph, ph && (c != 3'b011), wr,
                ph && (c == 3'b100 || c == 3'b101), ph && (c == 3'b110), c == 3'b110,
                ph && (c == 3'b001), ph && (c == 3'b010), c == 3'b010,
                ph && (c == 3'b000)};
    endfunction

    task automatic check(input logic [9:0] act, input logic [9:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b", tag, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] s, input logic [9:0] v, input string tag);
        exp_t e;
        @(negedge clk);
        stat = s;
        e.v = v; e.tag = tag;
        q.push_back(e);
    endtask

    // one bus cycle: address clock on code c, n transfer clocks on code later, then passive
    task automatic bus_cycle(input logic [2:0] c, input int n, input logic [2:0] later, input string tag);
        push(c, exp_vec(c, 1'b0), tag);
        for (int i = 0; i < n; i++) push(later, exp_vec(c, 1'b1), tag);
        push(3'b111, 10'b0, {tag, " R7"});
    endtask

    // monitor: pops one expected item per clock, after outputs settle
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(outs(), e.v, e.tag);
            end
        end
    end

    initial begin
        #1;
        check(outs(), 10'b0, "R1 in reset");
        repeat (3) @(negedge clk);
        check(outs(), 10'b0, "R1 in reset late");
        rst_n = 1'b1;
        push(3'b111, 10'b0, "R1 after reset");
        push(3'b111, 10'b0, "R1 idle");

        bus_cycle(3'b101, 3, 3'b101, "R3 R2 R5 mem read");
        bus_cycle(3'b100, 2, 3'b100, "R3 code fetch");
        bus_cycle(3'b110, 3, 3'b110, "R4 R6 mem write");
        bus_cycle(3'b001, 2, 3'b001, "R3 io read");
        bus_cycle(3'b010, 3, 3'b010, "R4 R6 io write");
        bus_cycle(3'b000, 2, 3'b000, "R3 R10 int ack");
        bus_cycle(3'b011, 2, 3'b011, "R3 R5 halt");
        bus_cycle(3'b110, 0, 3'b110, "R2 R7 short write");
        bus_cycle(3'b101, 4, 3'b010, "R8 code change read");
        bus_cycle(3'b010, 3, 3'b101, "R8 code change write");
        bus_cycle(3'b001, 1, 3'b001, "R3 back to back");

        sen = 1'b0;
        repeat (3) push(3'b101, 10'b0, "R9 strobe off");
        push(3'b111, 10'b0, "R9 strobe off");
        sen = 1'b1; iod = 1'b1;
        repeat (3) push(3'b110, 10'b0, "R9 io dedicated");
        push(3'b111, 10'b0, "R9 io dedicated");
        iod = 1'b0; agn = 1'b1;
        repeat (3) push(3'b001, 10'b0, "R9 grant high");
        push(3'b111, 10'b0, "R9 grant high");
        agn = 1'b0;
        bus_cycle(3'b110, 2, 3'b110, "R9 mode restored");

        repeat (3) @(negedge clk);
        if (q.size() != 0) check(10'b1, 10'b0, "scoreboard drained");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule